// File: doc/BRIEF.md
# Card Configuration Controller

This block is the card-side controller for a plug-and-play configuration protocol on a legacy parallel I/O bus. It monitors I/O writes and keeps the card in one of four protocol states. A write to a fixed index port selects a card-level register. A write to a fixed data port then applies a command to that register. The block holds the card select number (CSN) and the relocatable read-data port address. It decodes the wake, select-number, read-port and configuration-control commands.

The unlock key detector lives outside the block. It reports a recognised key as a single `key_seen` pulse. Bit-level isolation arbitration is also handled elsewhere. Two one-cycle pulses tell neighbouring logic when to act. One returns the logical devices to their power-up configuration. The other rewinds the resource-data byte pointer. Reads at the current read-data port are answered combinationally.

Top module: `ccsm_card_ctrl`

## Requirements
- R1: After a synchronous reset, the card is in Wait for Key with CSN 0 and read-data port address 0x203, and both pulses are low. The state encoding on `card_state` is Wait for Key = 0, Sleep = 1, Isolation = 2 and Config = 3.
- R2: A write to I/O address 0x279 latches the register index. A write to 0xA79 applies its data to the latched index. Writes to any other address change nothing.
- R3: In Wait for Key, every command write is ignored: state, CSN and read port all stay as they are. A `key_seen` pulse moves the card from Wait for Key to Sleep, and it has no effect in any other state.
- R4: A Wake command (index 0x03) received in Sleep compares its data with the CSN. On a match, the card enters Isolation when the data is 0 and Config otherwise. On a mismatch, the card stays in Sleep.
- R5: A matching Wake raises `res_ptr_clr` for exactly one cycle, starting on the clock edge that takes the write.
- R6: A write to index 0x00, outside Wait for Key, sets the read-data port address to data*4 + 3. In other words, the data byte becomes address bits [9:2], and bits [1:0] read as 1.
- R7: A write to index 0x06 loads the CSN in Isolation or Config, and is ignored in Sleep. A nonzero value written while in Isolation moves the card to Config.
- R8: Setting bit 1 of a write to index 0x02 returns the card to Wait for Key and leaves the CSN unchanged.
- R9: Setting bit 2 of a write to index 0x02 clears the CSN to 0. The state is unchanged unless bit 1 is also set.
- R10: Setting bit 0 of a write to index 0x02 raises `dev_reset` for exactly one cycle and leaves the CSN and state unchanged. The control bits clear themselves and leave no lasting state.
- R11: An I/O read at the read-data port address, outside Wait for Key, asserts `rd_valid` in the same cycle. `rd_data` then returns the CSN when the latched index is 0x06, and 0x00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_rd | input | 1 | I/O read strobe |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | I/O write data |
| key_seen | input | 1 | One-cycle pulse: unlock key recognised |
| card_state | output | 2 | Protocol state (encoding in R1) |
| csn | output | 8 | Card select number |
| rd_port | output | 16 | Current read-data port address |
| rd_valid | output | 1 | The read hits the read-data port |
| rd_data | output | 8 | Read response byte |
| dev_reset | output | 1 | One-cycle logical-device reset pulse |
| res_ptr_clr | output | 1 | One-cycle resource byte pointer reset pulse |

## Verification
The bench uses the default parameters: 16-bit address, 8-bit data, and index and data ports at 0x279 and 0xA79. With 8-bit data, every Wake value from 0 to 255 can be applied against a fixed nonzero CSN, which exercises the one match and all 255 mismatches, including zero. Every read-port selector value is also swept, and each one is checked both at the computed address and by a real read there. Directed sequences cover the control bits alone and combined, the commands that must be ignored in Wait for Key and Sleep, and writes to unrelated addresses.

// File: rtl/ccsm_pkg.sv
package ccsm_pkg;

    typedef enum logic [1:0] {
        ST_WAIT_KEY = 2'd0,
        ST_SLEEP    = 2'd1,
        ST_ISOLATE  = 2'd2,
        ST_CONFIG   = 2'd3
    } card_state_e;

    localparam int DATA_W = 8;

    localparam logic [DATA_W-1:0] IDX_RD_PORT = 8'h00;
    localparam logic [DATA_W-1:0] IDX_CTRL    = 8'h02;
    localparam logic [DATA_W-1:0] IDX_WAKE    = 8'h03;
    localparam logic [DATA_W-1:0] IDX_CSN     = 8'h06;

    localparam int CTRL_DEVRST_BIT = 0;
    localparam int CTRL_TOKEY_BIT  = 1;
    localparam int CTRL_CSNCLR_BIT = 2;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] index;
        logic [DATA_W-1:0] data;
    } cmd_t;

    function automatic logic [15:0] rd_port_addr(input logic [DATA_W-1:0] sel);
        return {{(16-DATA_W-2){1'b0}}, sel, 2'b11};
    endfunction

    function automatic logic cmd_is(input cmd_t c, input logic [DATA_W-1:0] idx);
        return c.valid && (c.index == idx);
    endfunction

endpackage

// File: rtl/ccsm_port_decode.sv
module ccsm_port_decode
    import ccsm_pkg::*;
#(
    parameter int                 ADDR_W     = 16,
    parameter logic [ADDR_W-1:0]  INDEX_PORT = 16'h0279,
    parameter logic [ADDR_W-1:0]  DATA_PORT  = 16'h0A79
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    output cmd_t              cmd,
    output logic [DATA_W-1:0] index_q
);

    logic index_wr;

    assign index_wr = io_wr && (io_addr == INDEX_PORT);

    always_ff @(posedge clk) begin
        if (rst) begin
            index_q <= '0;
        end else if (index_wr) begin
            index_q <= io_wdata;
        end
    end

    always_comb begin
        cmd.valid = io_wr && (io_addr == DATA_PORT);
        cmd.index = index_q;
        cmd.data  = io_wdata;
    end

endmodule

// File: rtl/ccsm_state_fsm.sv
module ccsm_state_fsm
    import ccsm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              key_seen,
    input  cmd_t              cmd,
    input  logic [DATA_W-1:0] csn_q,
    output card_state_e       state,
    output logic              res_ptr_clr
);

    card_state_e state_d;
    logic        wake_match;
    logic        to_key;

    assign wake_match = cmd_is(cmd, IDX_WAKE) && (state == ST_SLEEP) && (cmd.data == csn_q);
    assign to_key     = cmd_is(cmd, IDX_CTRL) && cmd.data[CTRL_TOKEY_BIT] && (state != ST_WAIT_KEY);

    always_comb begin
        state_d = state;
        unique case (state)
            ST_WAIT_KEY: begin
                if (key_seen) state_d = ST_SLEEP;
            end
            ST_SLEEP: begin
                if (wake_match) state_d = (cmd.data == '0) ? ST_ISOLATE : ST_CONFIG;
            end
            ST_ISOLATE: begin
                if (cmd_is(cmd, IDX_CSN) && cmd.data != '0) state_d = ST_CONFIG;
            end
            ST_CONFIG: begin
                state_d = ST_CONFIG;
            end
            default: state_d = ST_WAIT_KEY;
        endcase
        if (to_key) state_d = ST_WAIT_KEY;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_WAIT_KEY;
            res_ptr_clr <= 1'b0;
        end else begin
            state       <= state_d;
            res_ptr_clr <= wake_match;
        end
    end

    AST_WFK_EXIT_BY_KEY: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT_KEY && !key_seen) |=> (state == ST_WAIT_KEY)); // R3

    AST_SLEEP_EXIT_BY_CMD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLEEP && !(cmd_is(cmd, IDX_WAKE) || cmd_is(cmd, IDX_CTRL)))
        |=> (state == ST_SLEEP)); // R4

    AST_WAKE_PULSE_FROM_SLEEP: assert property (@(posedge clk) disable iff (rst)
        res_ptr_clr |-> ($past(state) == ST_SLEEP && state != ST_SLEEP)); // R5

endmodule

// File: rtl/ccsm_card_regs.sv
module ccsm_card_regs
    import ccsm_pkg::*;
#(
    parameter logic [DATA_W-1:0] RD_SEL_RESET = 8'h80
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              cmd,
    input  card_state_e       state,
    output logic [DATA_W-1:0] csn_q,
    output logic [DATA_W-1:0] rd_sel_q,
    output logic              dev_reset
);

    logic awake;
    logic csn_load;
    logic csn_clear;
    logic sel_load;
    logic ctrl_hit;

    assign awake     = (state != ST_WAIT_KEY);
    assign ctrl_hit  = cmd_is(cmd, IDX_CTRL) && awake;
    assign csn_load  = cmd_is(cmd, IDX_CSN) && (state == ST_ISOLATE || state == ST_CONFIG);
    assign csn_clear = ctrl_hit && cmd.data[CTRL_CSNCLR_BIT];
    assign sel_load  = cmd_is(cmd, IDX_RD_PORT) && awake;

    always_ff @(posedge clk) begin
        if (rst) begin
            csn_q     <= '0;
            rd_sel_q  <= RD_SEL_RESET;
            dev_reset <= 1'b0;
        end else begin
            if (csn_clear)     csn_q <= '0;
            else if (csn_load) csn_q <= cmd.data;
            if (sel_load)      rd_sel_q <= cmd.data;
            dev_reset <= ctrl_hit && cmd.data[CTRL_DEVRST_BIT];
        end
    end

    AST_CSN_FROZEN_IN_WFK: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT_KEY) |=> $stable(csn_q)); // R3

    AST_RDSEL_FROZEN_IN_WFK: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT_KEY) |=> $stable(rd_sel_q)); // R6

    AST_CSN_HELD_IN_SLEEP: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLEEP && !cmd_is(cmd, IDX_CTRL)) |=> $stable(csn_q)); // R7

endmodule

// File: rtl/ccsm_card_ctrl.sv
module ccsm_card_ctrl
    import ccsm_pkg::*;
#(
    parameter int                ADDR_W       = 16,
    parameter logic [ADDR_W-1:0] INDEX_PORT   = 16'h0279,
    parameter logic [ADDR_W-1:0] DATA_PORT    = 16'h0A79,
    parameter logic [7:0]        RD_SEL_RESET = 8'h80
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        io_wdata,
    input  logic              key_seen,
    output logic [1:0]        card_state,
    output logic [7:0]        csn,
    output logic [ADDR_W-1:0] rd_port,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              dev_reset,
    output logic              res_ptr_clr
);

    cmd_t              cmd;
    logic [DATA_W-1:0] index_q;
    logic [DATA_W-1:0] csn_q;
    logic [DATA_W-1:0] rd_sel_q;
    card_state_e       state;

    ccsm_port_decode #(
        .ADDR_W     (ADDR_W),
        .INDEX_PORT (INDEX_PORT),
        .DATA_PORT  (DATA_PORT)
    ) i_decode (
        .clk      (clk),
        .rst      (rst),
        .io_wr    (io_wr),
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .cmd      (cmd),
        .index_q  (index_q)
    );

    ccsm_state_fsm i_fsm (
        .clk         (clk),
        .rst         (rst),
        .key_seen    (key_seen),
        .cmd         (cmd),
        .csn_q       (csn_q),
        .state       (state),
        .res_ptr_clr (res_ptr_clr)
    );

    ccsm_card_regs #(
        .RD_SEL_RESET (RD_SEL_RESET)
    ) i_regs (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .state     (state),
        .csn_q     (csn_q),
        .rd_sel_q  (rd_sel_q),
        .dev_reset (dev_reset)
    );

    assign card_state = state;
    assign csn        = csn_q;
    assign rd_port    = ADDR_W'(rd_port_addr(rd_sel_q));
    assign rd_valid   = io_rd && (io_addr == rd_port) && (state != ST_WAIT_KEY);
    assign rd_data    = (rd_valid && index_q == IDX_CSN) ? csn_q : 8'h00;

    AST_DEVRST_FROM_CTRL: assert property (@(posedge clk) disable iff (rst)
        dev_reset |-> ($past(io_wr) && $past(io_addr) == DATA_PORT && $past(io_wdata[0]))); // R10

    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(dev_reset && res_ptr_clr)); // R5

endmodule

// File: tb/test_ccsm_card_ctrl.sv
module test_ccsm_card_ctrl;

    localparam logic [15:0] IDXP = 16'h0279;
    localparam logic [15:0] DATP = 16'h0A79;

    logic        clk = 1'b0;
    logic        rst;
    logic        io_wr;
    logic        io_rd;
    logic [15:0] io_addr;
    logic [7:0]  io_wdata;
    logic        key_seen;
    logic [1:0]  card_state;
    logic [7:0]  csn;
    logic [15:0] rd_port;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        dev_reset;
    logic        res_ptr_clr;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ccsm_card_ctrl i_ccsm_card_ctrl (
        .clk (clk), .rst (rst), .io_wr (io_wr), .io_rd (io_rd),
        .io_addr (io_addr), .io_wdata (io_wdata), .key_seen (key_seen),
        .card_state (card_state), .csn (csn), .rd_port (rd_port),
        .rd_valid (rd_valid), .rd_data (rd_data),
        .dev_reset (dev_reset), .res_ptr_clr (res_ptr_clr)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0; io_addr = '0; io_wdata = '0;
    endtask

    task automatic cmd_write(input logic [7:0] idx, input logic [7:0] d);
        io_write(IDXP, idx);
        io_write(DATP, d);
    endtask

    task automatic pulse_key();
        @(negedge clk); key_seen = 1'b1;
        @(negedge clk); key_seen = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, output logic v, output logic [7:0] d);
        @(negedge clk);
        io_rd = 1'b1; io_addr = a;
        #2;
        v = rd_valid; d = rd_data;
        @(negedge clk);
        io_rd = 1'b0; io_addr = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        logic       v;
        logic [7:0] d;
        rst = 1'b1; io_wr = 0; io_rd = 0; io_addr = 0; io_wdata = 0; key_seen = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 state", 16'(card_state), 16'd0);
        check("R1 csn", 16'(csn), 16'd0);
        check("R1 rd_port", rd_port, 16'h0203);
        check("R1 pulses", {14'd0, dev_reset, res_ptr_clr}, 16'd0);

        // R3 commands ignored in Wait for Key
        cmd_write(8'h03, 8'h00);
        check("R3 wake ignored", 16'(card_state), 16'd0);
        check("R3 no wake pulse", 16'(res_ptr_clr), 16'd0);
        cmd_write(8'h06, 8'h33);
        check("R3 csn ignored", 16'(csn), 16'd0);
        cmd_write(8'h00, 8'h10);
        check("R3 rdport ignored", rd_port, 16'h0203);
        cmd_write(8'h02, 8'h01);
        check("R3 devrst ignored", 16'(dev_reset), 16'd0);
        io_read(16'h0203, v, d);
        check("R11 no read in WFK", 16'(v), 16'd0);

        // R3 key
        pulse_key();
        check("R3 key to sleep", 16'(card_state), 16'd1);
        pulse_key();
        check("R3 key ignored in sleep", 16'(card_state), 16'd1);

        // R7 csn ignored in Sleep
        cmd_write(8'h06, 8'h44);
        check("R7 csn ignored in sleep", 16'(csn), 16'd0);

        // R4 mismatch then match 0 -> Isolation; R5 pulse
        cmd_write(8'h03, 8'h07);
        check("R4 mismatch stays sleep", 16'(card_state), 16'd1);
        check("R5 no pulse on mismatch", 16'(res_ptr_clr), 16'd0);
        cmd_write(8'h03, 8'h00);
        check("R4 wake0 to isolation", 16'(card_state), 16'd2);
        check("R5 pulse on match", 16'(res_ptr_clr), 16'd1);
        @(negedge clk);
        check("R5 pulse one cycle", 16'(res_ptr_clr), 16'd0);

        // R7 csn in Isolation
        cmd_write(8'h06, 8'h00);
        check("R7 zero csn stays isolation", 16'(card_state), 16'd2);
        cmd_write(8'h06, 8'h5A);
        check("R7 csn loaded", 16'(csn), 16'h005A);
        check("R7 nonzero csn to config", 16'(card_state), 16'd3);

        // R2 wrong addresses
        io_write(16'h027A, 8'h02);
        io_write(16'h0A78, 8'h06);
        io_write(16'h0A7A, 8'h06);
        check("R2 other addr no effect csn", 16'(csn), 16'h005A);
        check("R2 other addr no effect state", 16'(card_state), 16'd3);

        // R11 read back
        io_write(IDXP, 8'h06);
        io_read(16'h0203, v, d);
        check("R11 valid", 16'(v), 16'd1);
        check("R11 csn data", 16'(d), 16'h005A);
        io_read(16'h0204, v, d);
        check("R11 other addr not valid", 16'(v), 16'd0);
        io_write(IDXP, 8'h05);
        io_read(16'h0203, v, d);
        check("R11 other index zero", 16'(d), 16'd0);

        // R6 sweep of read port selector
        for (int s = 0; s < 256; s++) begin
            cmd_write(8'h00, 8'(s));
            check("R6 rd_port", rd_port, 16'(s * 4 + 3));
            io_write(IDXP, 8'h06);
            io_read(16'(s * 4 + 3), v, d);
            check("R6 read hit", {7'd0, v, d}, {8'd1, 8'h5A});
        end
        cmd_write(8'h00, 8'h80);

        // R10 device reset pulse
        cmd_write(8'h02, 8'h01);
        check("R10 pulse", 16'(dev_reset), 16'd1);
        check("R10 csn kept", 16'(csn), 16'h005A);
        check("R10 state kept", 16'(card_state), 16'd3);
        @(negedge clk);
        check("R10 self clear", 16'(dev_reset), 16'd0);

        // R9 csn clear
        cmd_write(8'h02, 8'h04);
        check("R9 csn cleared", 16'(csn), 16'd0);
        check("R9 state kept", 16'(card_state), 16'd3);
        cmd_write(8'h06, 8'h5A);
        check("R7 csn write in config", 16'(csn), 16'h005A);

        // R8 back to Wait for Key
        cmd_write(8'h02, 8'h02);
        check("R8 to wfk", 16'(card_state), 16'd0);
        check("R8 csn kept", 16'(csn), 16'h005A);

        // R4 exhaustive wake sweep against CSN 0x5A
        for (int w = 0; w < 256; w++) begin
            pulse_key();
            cmd_write(8'h03, 8'(w));
            check("R4 wake sweep state", 16'(card_state), (w == 8'h5A) ? 16'd3 : 16'd1);
            check("R5 wake sweep pulse", 16'(res_ptr_clr), (w == 8'h5A) ? 16'd1 : 16'd0);
            cmd_write(8'h02, 8'h02);
        end

        // R8 R9 combined
        pulse_key();
        cmd_write(8'h03, 8'h5A);
        cmd_write(8'h02, 8'h06);
        check("R8 combined to wfk", 16'(card_state), 16'd0);
        check("R9 combined csn clear", 16'(csn), 16'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule